// File: doc/BRIEF.md
# Asynchronous PSRAM Port Model with Power-Down Retention

This block is a synthesizable, clock-sampled behavioural model of a 16-bit pseudo-static RAM port. Each clock cycle it classifies the control pins into one action: deselected standby, power-down, read, write, or output-disable. It then updates a small word store, or presents read data, on a split tri-state data bus. The bus is split into a data output, a per-byte-lane output enable, and a data input. An active-low primary select and an active-high power enable gate the device. A write strobe, an output strobe and two active-low byte-lane enables choose the access.

The model also covers data retention across power-down. At the moment of entry it captures the retention mode from a mode input. On wake-up, every word at or above the retained boundary for that mode is overwritten with a fixed poison value. The boundaries are fixed fractions of the parameterised depth, so the same fractions hold at any size. A hold timer raises a flag when a read or write condition is held for longer than a parameterised number of cycles.

Top module: `psram_port_model`

## Requirements
- R1: When `sel_n` is high, the cycle is standby: `data_oe` is 0 and no word is written.
- R2: When `pwr_on` is low, `data_oe` is 0 and no word is written, whatever the other pins are.
- R3: Power-down is entered only from standby. If `pwr_on` goes low in the cycle right after an active cycle (`sel_n` low), that cycle is a standby cycle and stored data is untouched. The device powers down only when `pwr_on` is low in a cycle that starts from standby.
- R4: `lo_en_n` low selects data bits 7:0 and `hi_en_n` low selects bits 15:8. A write changes only the selected lanes of the addressed word.
- R5: With both `lo_en_n` and `hi_en_n` high, a read or write cycle is output-disable: `data_oe` is 0 and the word is unchanged.
- R6: A write (`wr_n` low) takes priority over a low `out_en_n`: the data is written and `data_oe` stays 0.
- R7: A read (`sel_n` low, `pwr_on` high, `wr_n` high, `out_en_n` low) drives only the selected lanes. `data_oe` bit 0 is the lower lane and bit 1 is the upper lane, and `data_out` reads 0 on any lane that is not driven.
- R8: `ret_mode` encodes the retained words after wake-up as follows: 0 keeps none, 1 keeps the lowest DEPTH/8, 2 keeps the lowest DEPTH/4, 3 keeps the lowest DEPTH/2. Every other word reads as POISON (default 16'hDEAD).
- R9: `ret_mode` is sampled in the cycle that enters power-down. Changes to it during power-down have no effect on retention.
- R10: A poisoned word takes new data on a later write. A byte write replaces only the selected lane of the poison pattern.
- R11: `hold_viol` is high in the (MAX_HOLD+1)th and later consecutive cycles of a read or write with at least one lane selected. It is low at all other times, including during held output-disable cycles.
- R12: The first cycle with `pwr_on` high after power-down is a wake cycle. No read or write occurs in it, even if `sel_n` is low.
- R13: After reset the device is in standby and every word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Primary device select, active low |
| pwr_on | input | 1 | Power enable; low requests power-down |
| wr_n | input | 1 | Write strobe, active low |
| out_en_n | input | 1 | Output strobe, active low |
| lo_en_n | input | 1 | Lower byte lane enable, active low |
| hi_en_n | input | 1 | Upper byte lane enable, active low |
| addr | input | ADDR_W | Word address |
| ret_mode | input | 2 | Retention mode captured at power-down entry |
| data_in | input | 16 | Write data from the bus |
| data_out | output | 16 | Read data to the bus |
| data_oe | output | 2 | Per-lane bus drive enable (bit 0 lower, bit 1 upper) |
| hold_viol | output | 1 | Read or write condition held too long |

## Verification
The hardest situation to reach is a power-down request arriving straight out of an active cycle. Entry must then be deferred, and reaching this depends on the internal state left by the previous cycle. The stimulus writes a high-address word and reads it. It then drops `pwr_on` for exactly one cycle with retention set to keep nothing, and reads the word back. Any premature entry would show up as the poison pattern. The retention windows are probed at the last kept word and the first lost word for each mode. Mode capture is checked by changing `ret_mode` while the device is asleep.

// File: rtl/psram_port_pkg.sv
// Shared types for the PSRAM port model.
// Assumes a 16-bit bus split into two byte lanes.
package psram_port_pkg;
    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        PS_STANDBY = 2'd0,
        PS_ACTIVE  = 2'd1,
        PS_PDOWN   = 2'd2
    } pwr_state_e;

    typedef enum logic [1:0] {
        RM_NONE    = 2'd0,
        RM_EIGHTH  = 2'd1,
        RM_QUARTER = 2'd2,
        RM_HALF    = 2'd3
    } ret_mode_e;

    typedef struct packed {
        logic             rd;     // read with a lane selected
        logic             wr;     // write with a lane selected
        logic [LANES-1:0] lanes;  // selected byte lanes
        logic             busy;   // read or write condition counted by the hold timer
    } port_cmd_t;
endpackage

// File: rtl/psram_cmd_decode.sv
// Combinational decode of the control pins into one cycle action.
// Assumes the power state comes from psram_power_ctrl; no access is
// allowed while that state is power-down (this includes the wake cycle).
module psram_cmd_decode
    import psram_port_pkg::*;
(
    input  logic       sel_n,
    input  logic       pwr_on,
    input  logic       wr_n,
    input  logic       out_en_n,
    input  logic       lo_en_n,
    input  logic       hi_en_n,
    input  pwr_state_e state_q,
    output port_cmd_t  cmd
);
    logic selected;
    logic any_lane;

    // Classify the cycle: write wins over read, empty lane mask disables output.
    always_comb begin
        selected   = !sel_n && pwr_on && (state_q != PS_PDOWN);
        cmd.lanes  = {!hi_en_n, !lo_en_n};
        any_lane   = |cmd.lanes;
        cmd.wr     = selected && !wr_n && any_lane;
        cmd.rd     = selected && wr_n && !out_en_n && any_lane;
        cmd.busy   = cmd.wr || cmd.rd;
    end
endmodule

// File: rtl/psram_power_ctrl.sv
// Power state tracker: standby, active, power-down.
// Power-down is only entered from standby; a request right after an
// active cycle first yields a standby cycle. The retention mode is
// captured on entry. Leaving power-down produces a one-cycle wake pulse.
module psram_power_ctrl
    import psram_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_n,
    input  logic       pwr_on,
    input  logic [1:0] ret_mode,
    output pwr_state_e state_q,
    output logic       wake,
    output ret_mode_e  pd_mode_q
);
    pwr_state_e state_d;

    // Next-state selection from the pins and the present state.
    always_comb begin
        if (!pwr_on)
            state_d = (state_q == PS_ACTIVE) ? PS_STANDBY : PS_PDOWN;
        else if (state_q == PS_PDOWN)
            state_d = PS_STANDBY;
        else
            state_d = sel_n ? PS_STANDBY : PS_ACTIVE;
    end

    assign wake = (state_q == PS_PDOWN) && pwr_on;

    // State register with synchronous reset into standby.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PS_STANDBY;
        else
            state_q <= state_d;
    end

    // Capture the retention mode in the cycle that enters power-down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pd_mode_q <= RM_NONE;
        else if ((state_q != PS_PDOWN) && (state_d == PS_PDOWN))
            pd_mode_q <= ret_mode_e'(ret_mode);
    end

    // R3
    pdown_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_PDOWN) |-> ($past(state_q) != PS_ACTIVE));

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_PDOWN && $past(state_q) == PS_PDOWN) |-> $stable(pd_mode_q));
endmodule

// File: rtl/psram_word_store.sv
// Word array with byte-lane writes and wake-up poisoning.
// Assumes at most one of wake and wr per cycle (the decoder blocks
// access during the wake cycle). ADDR_W must be at least 3.
module psram_word_store
    import psram_port_pkg::*;
#(
    parameter int              ADDR_W = 8,
    parameter logic [DATA_W-1:0] POISON = 16'hDEAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    input  logic [LANES-1:0]  lanes,
    input  logic              wake,
    input  ret_mode_e         pd_mode,
    output logic [DATA_W-1:0] rword
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int IDX_W = ADDR_W + 1;

    logic [IDX_W-1:0]  keep_words;
    logic [DATA_W-1:0] words [DEPTH];

    // Retained word count for the captured mode, as a fraction of DEPTH.
    always_comb begin
        case (pd_mode)
            RM_EIGHTH:  keep_words = IDX_W'(DEPTH >> 3);
            RM_QUARTER: keep_words = IDX_W'(DEPTH >> 2);
            RM_HALF:    keep_words = IDX_W'(DEPTH >> 1);
            default:    keep_words = '0;
        endcase
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        localparam logic [IDX_W-1:0] CELL_IDX = IDX_W'(i);
        logic [DATA_W-1:0] cell_q;

        // One word: clear on reset, poison on wake if outside the window, else lane writes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_q <= '0;
            else if (wake && (CELL_IDX >= keep_words))
                cell_q <= POISON;
            else if (wr && (addr == CELL_IDX[ADDR_W-1:0])) begin
                for (int l = 0; l < LANES; l++)
                    if (lanes[l])
                        cell_q[l*8 +: 8] <= wdata[l*8 +: 8];
            end
        end

        assign words[i] = cell_q;
    end

    assign rword = words[addr];

    // R12
    wake_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> !wr);
endmodule

// File: rtl/psram_hold_timer.sv
// Counts consecutive cycles of a held read or write condition and flags
// a violation once the count passes MAX_HOLD. The counter saturates.
module psram_hold_timer #(
    parameter int MAX_HOLD = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    output logic hold_viol
);
    localparam int CNT_W = $clog2(MAX_HOLD + 1);

    logic [CNT_W-1:0] cnt_q;

    // Consecutive busy-cycle counter, cleared on any idle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!busy)
            cnt_q <= '0;
        else if (cnt_q != CNT_W'(MAX_HOLD))
            cnt_q <= cnt_q + 1'b1;
    end

    assign hold_viol = busy && (cnt_q == CNT_W'(MAX_HOLD));

    // R11
    viol_needs_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_viol |-> $past(busy));
endmodule

// File: rtl/psram_port_model.sv
// Top of the PSRAM port model. Ties together the pin decode, the power
// state tracker, the word store and the hold timer, and drives the
// split tri-state data bus per byte lane.
// Assumes all pins are sampled on clk; the bus is combinational from them.
module psram_port_model
    import psram_port_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                MAX_HOLD = 100,
    parameter logic [DATA_W-1:0] POISON   = 16'hDEAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              pwr_on,
    input  logic              wr_n,
    input  logic              out_en_n,
    input  logic              lo_en_n,
    input  logic              hi_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        ret_mode,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic [LANES-1:0]  data_oe,
    output logic              hold_viol
);
    pwr_state_e        state_q;
    ret_mode_e         pd_mode_q;
    logic              wake;
    port_cmd_t         cmd;
    logic [DATA_W-1:0] rword;

    psram_power_ctrl u_power (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (sel_n),
        .pwr_on    (pwr_on),
        .ret_mode  (ret_mode),
        .state_q   (state_q),
        .wake      (wake),
        .pd_mode_q (pd_mode_q)
    );

    psram_cmd_decode u_decode (
        .sel_n    (sel_n),
        .pwr_on   (pwr_on),
        .wr_n     (wr_n),
        .out_en_n (out_en_n),
        .lo_en_n  (lo_en_n),
        .hi_en_n  (hi_en_n),
        .state_q  (state_q),
        .cmd      (cmd)
    );

    psram_word_store #(
        .ADDR_W (ADDR_W),
        .POISON (POISON)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wdata   (data_in),
        .wr      (cmd.wr),
        .lanes   (cmd.lanes),
        .wake    (wake),
        .pd_mode (pd_mode_q),
        .rword   (rword)
    );

    psram_hold_timer #(
        .MAX_HOLD (MAX_HOLD)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (cmd.busy),
        .hold_viol (hold_viol)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Drive a lane only on a read that selects it.
        assign data_oe[l]         = cmd.rd && cmd.lanes[l];
        assign data_out[l*8 +: 8] = data_oe[l] ? rword[l*8 +: 8] : 8'h00;
    end

    // R1
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> (data_oe == '0));

    // R2
    pdown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> (data_oe == '0));

    // R5
    no_lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_en_n && hi_en_n) |-> (data_oe == '0));

    // R6
    write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (data_oe == '0));

    // R12
    asleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_PDOWN) |-> (data_oe == '0));
endmodule

// File: tb/psram_port_model_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module psram_port_model_tb_top;
    localparam int          ADDR_W = 8;
    localparam int          DEPTH  = 1 << ADDR_W;
    localparam int          HOLD   = 100;
    localparam logic [15:0] POISON = 16'hDEAD;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              sel_n, pwr_on, wr_n, out_en_n, lo_en_n, hi_en_n;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        ret_mode;
    logic [15:0]       data_in;
    logic [15:0]       data_out;
    logic [1:0]        data_oe;
    logic              hold_viol;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    psram_port_model #(.ADDR_W(ADDR_W), .MAX_HOLD(HOLD), .POISON(POISON)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .pwr_on(pwr_on), .wr_n(wr_n),
        .out_en_n(out_en_n), .lo_en_n(lo_en_n), .hi_en_n(hi_en_n), .addr(addr),
        .ret_mode(ret_mode), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .hold_viol(hold_viol)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic p, input logic w, input logic o,
                         input logic lo, input logic hi, input logic [ADDR_W-1:0] a,
                         input logic [15:0] d);
        sel_n = s; pwr_on = p; wr_n = w; out_en_n = o;
        lo_en_n = lo; hi_en_n = hi; addr = a; data_in = d;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        drive(1, 1, 1, 1, 1, 1, '0, '0);
        step();
    endtask

    // lo/hi are active-low lane enables
    task automatic wr_word(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                           input logic lo, input logic hi);
        drive(0, 1, 0, 1, lo, hi, a, d);
        step();
    endtask

    task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic lo, input logic hi,
                          input logic [15:0] exp_d, input logic [1:0] exp_oe, input string tag);
        drive(0, 1, 1, 0, lo, hi, a, '0);
        #1;
        chk(data_out == exp_d, tag, data_out, exp_d);
        chk(data_oe == exp_oe, tag, data_oe, exp_oe);
        step();
    endtask

    // Power down from standby with the given mode, stay asleep, then wake.
    task automatic sleep_wake(input logic [1:0] mode, input logic [1:0] mode_late);
        idle();
        ret_mode = mode;
        drive(1, 0, 1, 1, 1, 1, '0, '0);
        step();
        ret_mode = mode_late;
        repeat (3) step();
        drive(0, 1, 0, 0, 0, 0, 8'd9, 16'h7E7E);
        #1;
        chk(data_oe == 2'b00, "R12 wake cycle drive", data_oe, 2'b00);
        step();
        idle();
        ret_mode = 2'd0;
    endtask

    task automatic t_reset();
        idle();
        chk(data_oe == 2'b00, "R13 reset standby", data_oe, 2'b00);
        rd_chk(8'd5, 0, 0, 16'h0000, 2'b11, "R13 reset contents");
    endtask

    task automatic t_lanes();
        wr_word(8'd3, 16'hA1B2, 0, 0);
        wr_word(8'd3, 16'hCC55, 1, 0);
        rd_chk(8'd3, 0, 1, 16'h00B2, 2'b01, "R7 lower lane only");
        rd_chk(8'd3, 1, 0, 16'hCC00, 2'b10, "R7 upper lane only");
        rd_chk(8'd3, 0, 0, 16'hCCB2, 2'b11, "R4 upper byte write");
        wr_word(8'd3, 16'h1177, 0, 1);
        rd_chk(8'd3, 0, 0, 16'hCC77, 2'b11, "R4 lower byte write");
    endtask

    task automatic t_outdis();
        wr_word(8'd3, 16'hFFFF, 1, 1);
        drive(0, 1, 1, 0, 1, 1, 8'd3, '0);
        #1;
        chk(data_oe == 2'b00, "R5 output disable read", data_oe, 2'b00);
        step();
        rd_chk(8'd3, 0, 0, 16'hCC77, 2'b11, "R5 no-lane write ignored");
    endtask

    task automatic t_wprio();
        drive(0, 1, 0, 0, 0, 0, 8'd4, 16'h1234);
        #1;
        chk(data_oe == 2'b00, "R6 write with strobe low", data_oe, 2'b00);
        step();
        rd_chk(8'd4, 0, 0, 16'h1234, 2'b11, "R6 write committed");
    endtask

    task automatic t_standby();
        drive(1, 1, 0, 0, 0, 0, 8'd4, 16'h9999);
        #1;
        chk(data_oe == 2'b00, "R1 deselected drive", data_oe, 2'b00);
        step();
        rd_chk(8'd4, 0, 0, 16'h1234, 2'b11, "R1 deselected write ignored");
    endtask

    task automatic t_pwr_off();
        idle();
        ret_mode = 2'd3;
        drive(0, 0, 0, 0, 0, 0, 8'd4, 16'h7777);
        #1;
        chk(data_oe == 2'b00, "R2 power-down drive", data_oe, 2'b00);
        step();
        drive(0, 0, 1, 0, 0, 0, 8'd4, '0);
        #1;
        chk(data_oe == 2'b00, "R2 read while asleep", data_oe, 2'b00);
        step();
        drive(0, 1, 1, 1, 1, 1, '0, '0);
        step();
        ret_mode = 2'd0;
        idle();
        rd_chk(8'd4, 0, 0, 16'h1234, 2'b11, "R2 write ignored, kept word");
    endtask

    task automatic t_retain(input logic [1:0] mode);
        int keep;
        keep = (mode == 2'd0) ? 0 : (DEPTH >> (4 - mode));
        wr_word(8'd0, 16'h1111, 0, 0);
        if (keep > 0) wr_word(ADDR_W'(keep - 1), 16'h2222, 0, 0);
        if (keep > 0) wr_word(ADDR_W'(keep), 16'h3333, 0, 0);
        wr_word(ADDR_W'(DEPTH - 1), 16'h4444, 0, 0);
        sleep_wake(mode, mode);
        rd_chk(8'd0, 0, 0, (keep > 0) ? 16'h1111 : POISON, 2'b11, "R8 lowest word");
        if (keep > 0) rd_chk(ADDR_W'(keep - 1), 0, 0, 16'h2222, 2'b11, "R8 last kept word");
        if (keep > 0) rd_chk(ADDR_W'(keep), 0, 0, POISON, 2'b11, "R8 first lost word");
        rd_chk(ADDR_W'(DEPTH - 1), 0, 0, POISON, 2'b11, "R8 top word");
    endtask

    task automatic t_mode_latch();
        wr_word(8'd100, 16'hBEEF, 0, 0);
        sleep_wake(2'd3, 2'd0);
        rd_chk(8'd100, 0, 0, 16'hBEEF, 2'b11, "R9 mode held while asleep");
    endtask

    task automatic t_rewrite();
        sleep_wake(2'd1, 2'd1);
        rd_chk(8'd200, 0, 0, POISON, 2'b11, "R10 poisoned before write");
        wr_word(8'd200, 16'h4400, 1, 0);
        rd_chk(8'd200, 0, 0, {8'h44, POISON[7:0]}, 2'b11, "R10 byte write on poison");
        wr_word(8'd200, 16'h0F0F, 0, 0);
        rd_chk(8'd200, 0, 0, 16'h0F0F, 2'b11, "R10 word rewrite");
    endtask

    task automatic t_pd_from_active();
        wr_word(8'd200, 16'h5A5A, 0, 0);
        ret_mode = 2'd0;
        rd_chk(8'd200, 0, 0, 16'h5A5A, 2'b11, "R3 read before request");
        drive(1, 0, 1, 1, 1, 1, '0, '0);
        #1;
        chk(data_oe == 2'b00, "R3 request cycle drive", data_oe, 2'b00);
        step();
        rd_chk(8'd200, 0, 0, 16'h5A5A, 2'b11, "R3 no power-down from active");
        idle();
    endtask

    task automatic t_hold();
        int early_bad;
        idle();
        early_bad = 0;
        drive(0, 1, 1, 0, 0, 0, 8'd1, '0);
        for (int k = 1; k <= HOLD; k++) begin
            #1;
            if (hold_viol !== 1'b0) early_bad++;
            step();
        end
        chk(early_bad == 0, "R11 no flag within limit", early_bad, 0);
        #1;
        chk(hold_viol == 1'b1, "R11 flag past limit", hold_viol, 1);
        step();
        idle();
        #1;
        chk(hold_viol == 1'b0, "R11 flag clears", hold_viol, 0);
        early_bad = 0;
        drive(0, 1, 1, 0, 1, 1, 8'd1, '0);
        for (int k = 1; k <= HOLD + 20; k++) begin
            #1;
            if (hold_viol !== 1'b0) early_bad++;
            step();
        end
        chk(early_bad == 0, "R11 output disable not counted", early_bad, 0);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        ret_mode = 2'd0;
        drive(1, 1, 1, 1, 1, 1, '0, '0);
        repeat (3) step();
        rst_n = 1'b1;
        t_reset();
        t_lanes();
        t_outdis();
        t_wprio();
        t_standby();
        t_pwr_off();
        for (int m = 0; m < 4; m++) t_retain(2'(m));
        t_mode_latch();
        t_rewrite();
        t_pd_from_active();
        t_hold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule